// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block times the low and high halves of the serial clock for a two-wire bus master. A configuration word carries one divider for the low half, one for the high half and a shared power-of-two exponent. Each half lasts the divider shifted left by the exponent, plus a fixed offset of system clocks. With equal dividers the bus clock runs at F / (2 × (div × 2^exp + OFFSET)).

The bit engine that sits next to this block drives `en_i` to run the generator. The generator returns `scl_o`, a one-cycle `edge_o` strobe at every phase boundary, and `phase_o`, the level of the phase that is starting. The bit engine can raise `hold_i` to stretch a low phase for as long as it needs. The configuration is sampled only when a low phase starts, so a value changed mid-period never cuts a pulse short. Software works out the divider values. This block does not detect clock stretching by a slave.

Top module: `scl_wavegen`

## Requirements
- R1: While `rst_ni` is low, `scl_o` is 1, `edge_o` is 0 and `phase_o` is 1.
- R2: When `en_i` is sampled high while idle, the next cycle shows `scl_o`=0, `edge_o`=1 and `phase_o`=0, and a low phase begins.
- R3: A low phase lasts (`cfg_i[7:0]` << e) + OFFSET cycles. e is `cfg_i[18:16]`, limited as R6 states, and OFFSET defaults to 4.
- R4: A high phase lasts (`cfg_i[15:8]` << e) + OFFSET cycles, and low and high phases alternate.
- R5: A divider of 0 gives a phase of exactly OFFSET cycles.
- R6: An exponent field above MAX_EXP (default 5) acts as MAX_EXP.
- R7: `cfg_i` is captured only in the cycle that starts a low phase. A change at any other time has no effect on the current low phase or on the high phase that follows it.
- R8: While `hold_i` is sampled high during a low phase, `scl_o` stays 0. The low phase then ends (low length) cycles after the last clock edge at which `hold_i` was high.
- R9: `hold_i` has no effect during a high phase.
- R10: `edge_o` is high for exactly one cycle at each phase boundary. In that cycle `phase_o` equals the new `scl_o` level: 1 when a high phase begins, 0 when a low phase begins.
- R11: When `en_i` is sampled low, the next cycle shows `scl_o`=1 with no strobe. A later enable restarts the generator with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the generator |
| hold_i | input | 1 | Stretch the current low phase |
| cfg_i | input | 19 | {exponent[2:0], high divider[7:0], low divider[7:0]} |
| scl_o | output | 1 | Bus clock level |
| edge_o | output | 1 | One-cycle phase-boundary strobe |
| phase_o | output | 1 | Level of the phase that is beginning |

## Verification
All outputs are registered. An enable, a disable or a configuration change first appears on the ports one cycle after the clock edge that samples it. A phase boundary appears exactly (phase length) edges after the previous boundary. The bench drives inputs on the falling edge. It measures each phase as the number of falling edges between two strobes and compares that count with the value it computes from the divider, the limited exponent and the offset. For a hold, the count runs from the strobe that started the low phase and is expected to be the number of held edges plus the low length.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } wg_state_e;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  parameter int OFFSET  = 4,
  parameter int LEN_W   = DIV_W + MAX_EXP + 1
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [LEN_W-1:0] last_o
);
  logic [EXP_W-1:0] eff_exp;

  always_comb begin
    if (32'(exp_i) > MAX_EXP) eff_exp = EXP_W'(MAX_EXP);
    else                      eff_exp = exp_i;
    // terminal count = length - 1
    last_o = (LEN_W'(div_i) << eff_exp) + LEN_W'(OFFSET - 1);
  end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] last_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + LEN_W'(1);
  end

  assign done_o = (cnt_q == last_i);
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  parameter int OFFSET  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       hold_i,
  input  logic [2*DIV_W+EXP_W-1:0]   cfg_i,
  output logic                       scl_o,
  output logic                       edge_o,
  output logic                       phase_o
);
  localparam int CFG_W = 2 * DIV_W + EXP_W;
  localparam int LEN_W = DIV_W + MAX_EXP + 1;

  wg_state_e        state_q, state_d;
  logic [CFG_W-1:0] cfg_q;
  logic             scl_q, scl_d, edge_q, edge_d, phase_q, phase_d;
  logic             load_cfg, cnt_clr, done;
  logic [LEN_W-1:0] last_w [2];
  logic [LEN_W-1:0] last_sel;

  // index 0: low phase, index 1: high phase
  for (genvar g = 0; g < 2; g++) begin : g_len
    scl_phase_len #(
      .DIV_W(DIV_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP),
      .OFFSET(OFFSET), .LEN_W(LEN_W)
    ) i_len (
      .div_i (cfg_q[g*DIV_W +: DIV_W]),
      .exp_i (cfg_q[2*DIV_W +: EXP_W]),
      .last_o(last_w[g])
    );
  end

  assign last_sel = (state_q == ST_HIGH) ? last_w[1] : last_w[0];

  scl_phase_cnt #(.LEN_W(LEN_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .last_i(last_sel),
    .done_o(done)
  );

  always_comb begin
    state_d  = state_q;
    scl_d    = scl_q;
    phase_d  = phase_q;
    edge_d   = 1'b0;
    load_cfg = 1'b0;
    cnt_clr  = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      scl_d   = 1'b1;
      phase_d = 1'b1;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_LOW;
          load_cfg = 1'b1;
          cnt_clr  = 1'b1;
          scl_d    = 1'b0;
          phase_d  = 1'b0;
          edge_d   = 1'b1;
        end
        ST_LOW: begin
          if (hold_i) begin
            cnt_clr = 1'b1;
          end else if (done) begin
            state_d = ST_HIGH;
            cnt_clr = 1'b1;
            scl_d   = 1'b1;
            phase_d = 1'b1;
            edge_d  = 1'b1;
          end
        end
        ST_HIGH: begin
          if (done) begin
            state_d  = ST_LOW;
            load_cfg = 1'b1;
            cnt_clr  = 1'b1;
            scl_d    = 1'b0;
            phase_d  = 1'b0;
            edge_d   = 1'b1;
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  // the loaded word takes effect in the cycle after the boundary; the counter is cleared then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      scl_q   <= 1'b1;
      edge_q  <= 1'b0;
      phase_q <= 1'b1;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
      if (load_cfg) cfg_q <= cfg_i;
    end
  end

  assign scl_o   = scl_q;
  assign edge_o  = edge_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
  parameter int OFFSET = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic hold_i,
  input logic scl_o,
  input logic edge_o,
  input logic phase_o
);
  int unsigned low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run <= 0;
    else if (!scl_o) low_run <= low_run + 1;
    else             low_run <= 0;
  end

  AST_DISABLE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> scl_o && !edge_o); // R11
  AST_EDGE_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> scl_o != $past(scl_o)); // R10
  AST_FALL_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> edge_o && !phase_o); // R2
  AST_RISE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) && $past(en_i) |-> edge_o && phase_o); // R10
  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && hold_i && !scl_o |=> !scl_o); // R8
  AST_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) && edge_o |-> low_run >= OFFSET); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && (OFFSET > 1) |=> !edge_o); // R10
endmodule

bind scl_wavegen scl_wavegen_chk #(.OFFSET(OFFSET)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hold_i(hold_i),
  .scl_o(scl_o), .edge_o(edge_o), .phase_o(phase_o)
);

// File: tb/test_scl_wavegen.sv
`timescale 1ns/1ps
module test_scl_wavegen;
  localparam int OFFSET  = 4;
  localparam int MAX_EXP = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        hold_i = 1'b0;
  logic [18:0] cfg_i = '0;
  logic        scl_o, edge_o, phase_o;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk_i = ~clk_i;

  scl_wavegen i_scl_wavegen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hold_i(hold_i),
    .cfg_i(cfg_i), .scl_o(scl_o), .edge_o(edge_o), .phase_o(phase_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int plen(input int d, input int e);
    int ee = (e > MAX_EXP) ? MAX_EXP : e;
    return (d << ee) + OFFSET;
  endfunction

  // falling edges until the next strobe
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!edge_o && n < 70000);
  endtask

  task automatic start(input int lo, input int hi, input int e);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(scl_o && !edge_o, "R11", {scl_o, edge_o}, 2);
    cfg_i = {3'(e), 8'(hi), 8'(lo)};
    en_i = 1'b1;
    @(negedge clk_i);
    chk(edge_o && !phase_o && !scl_o, "R2", {edge_o, phase_o, scl_o}, 4);
  endtask

  task automatic period(input int lo, input int hi, input int e, input string tag);
    int n;
    gap(n);
    chk(n == plen(lo, e), {tag, " low (R3)"}, n, plen(lo, e));
    chk(phase_o && scl_o, "R10 high begin", {phase_o, scl_o}, 3);
    gap(n);
    chk(n == plen(hi, e), {tag, " high (R4)"}, n, plen(hi, e));
    chk(!phase_o && !scl_o, "R10 low begin", {phase_o, scl_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dv[5] = '{0, 1, 3, 9, 25};
    int n;
    repeat (3) @(negedge clk_i);
    chk(scl_o && !edge_o && phase_o, "R1", {scl_o, edge_o, phase_o}, 5);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(scl_o && !edge_o, "R1 idle", {scl_o, edge_o}, 2);

    // sweep exponent (incl. R6 clamp) and dividers (incl. R5 zero)
    for (int e = 0; e < 8; e++) begin
      for (int i = 0; i < 5; i++) begin
        string tg = (e > MAX_EXP) ? "R6" : (dv[i] == 0) ? "R5" : "R3";
        start(dv[i], dv[(i + 2) % 5], e);
        period(dv[i], dv[(i + 2) % 5], e, tg);
      end
    end
    start(255, 0, 5);
    period(255, 0, 5, "R3 max");

    // R7: change mid low phase, takes effect at next low
    start(5, 7, 1);
    cfg_i = {3'd0, 8'd2, 8'd1};
    period(5, 7, 1, "R7 old");
    period(1, 2, 0, "R7 new");

    // R8: hold for 20 edges in low phase
    start(5, 5, 0);
    hold_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(!scl_o && !edge_o, "R8 held", {scl_o, edge_o}, 0);
    hold_i = 1'b0;
    gap(n);
    chk(n + 20 == 20 + plen(5, 0), "R8 resume", n + 20, 20 + plen(5, 0));
    // R9: hold through high phase has no effect
    hold_i = 1'b1;
    gap(n);
    chk(n == plen(5, 0), "R9 high", n, plen(5, 0));
    hold_i = 1'b0;
    gap(n);
    chk(n == plen(5, 0), "R9 next low", n, plen(5, 0));

    // R11: disable mid-phase
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(scl_o && !edge_o, "R11 release", {scl_o, edge_o}, 2);
    repeat (30) @(negedge clk_i);
    chk(scl_o && !edge_o, "R11 stays", {scl_o, edge_o}, 2);
    start(2, 3, 2);
    period(2, 3, 2, "R11 restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule